// File: doc/BRIEF.md
# Hashed-Index TLB Lookup Unit

This unit turns a 32-bit virtual address into a physical address for a processor core using 4 KiB pages. The translation lookaside buffer is set associative, with 32 sets of 4 ways. The set for a page can be formed from the virtual page number alone. It can also be formed by XOR with the low bits of the current address-space identifier, so that different address spaces that use the same virtual pages spread across different sets. Each lookup gives a registered result one cycle later: hit, miss or address error, the physical address, and a cacheable attribute.

The top three address bits select a region. Two kernel windows skip the TLB: the physical address is the virtual address with its window base removed, and one window is cacheable while the other is not. The control region at the top of the map passes through unchanged. The top 64 MiB of the user region is reserved, and any access there is reported as an address error and never translated. The user region and the upper kernel region go through the TLB.

Software loads entries through a write port. Within the addressed set, the way is picked by a round-robin counter kept for that set. A single flush input clears every entry. On a miss the unit only reports the miss; page-table walking and exception handling belong to other logic.

Top module: `hashtlb_top`

## Requirements
- R1: On every hit, physical address bits 11..0 equal virtual address bits 11..0.
- R2: The set index is req_va[16:12] when hash_en is 0, and cur_asid[4:0] XOR req_va[16:12] when hash_en is 1. Writes form their index the same way from wr_vpn[4:0] and wr_asid.
- R3: An entry stores only wr_vpn[19:5] as its tag. A TLB hit needs a valid entry in the indexed set whose tag equals req_va[31:17] and whose ASID equals cur_asid. Virtual pages that differ only in bits 16..12 but land in the same set match the same entry.
- R4: An entry written with wr_shared=1 matches any cur_asid.
- R5: An address in 0x80000000–0x9FFFFFFF hits without a TLB lookup. Its physical address is va − 0x80000000 and rsp_cacheable=1.
- R6: An address in 0xA0000000–0xBFFFFFFF hits without a TLB lookup. Its physical address is va − 0xA0000000 and rsp_cacheable=0.
- R7: An address at or above 0xE0000000 hits with physical address equal to the virtual address and rsp_cacheable=0.
- R8: An address in 0x7C000000–0x7FFFFFFF raises rsp_addr_err, with rsp_hit=0, rsp_miss=0, rsp_pa=0 and rsp_cacheable=0.
- R9: rsp_valid is req_valid delayed by one cycle. When it is high, exactly one of rsp_hit, rsp_miss and rsp_addr_err is high. A miss drives rsp_pa=0 and rsp_cacheable=0. A TLB hit returns {PPN, offset} and the entry's cacheable bit.
- R10: Writes to a set fill ways 0,1,2,3 in turn and then wrap, so the fifth write to a set overwrites the first. Each counter starts at way 0 after reset.
- R11: flush_all invalidates every entry in one cycle. A write in the same cycle as a flush is dropped.
- R12: A lookup in the same cycle as a write or a flush sees the contents as they were before that cycle.
- R13: Addresses in 0x00000000–0x7BFFFFFF and 0xC0000000–0xDFFFFFFF are translated through the TLB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request |
| req_va | input | 32 | Virtual address to translate |
| cur_asid | input | 8 | Current address-space identifier |
| hash_en | input | 1 | 1: set index hashed with ASID |
| wr_en | input | 1 | Load one TLB entry |
| wr_vpn | input | 20 | Virtual page number of the new entry |
| wr_asid | input | 8 | ASID of the new entry |
| wr_ppn | input | 20 | Physical page number of the new entry |
| wr_cache | input | 1 | Cacheable attribute of the new entry |
| wr_shared | input | 1 | New entry ignores ASID on compare |
| flush_all | input | 1 | Invalidate all entries |
| rsp_valid | output | 1 | Result valid |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | No matching entry |
| rsp_addr_err | output | 1 | Reserved user address |
| rsp_pa | output | 32 | Physical address |
| rsp_cacheable | output | 1 | Cacheable attribute |

## Verification
A lookup can fall in the same cycle as an entry load or as a flush. Each pairing is forced by driving both inputs on one clock edge, and the request goes to the exact page that the load creates or that the flush removes. The same-cycle result is judged against the old contents: a miss for the load and a hit for the flush. A repeat of the lookup on the next cycle must show the new contents. A flush combined with a load is judged by a later lookup of the loaded page, which must miss.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;
    localparam int VA_W     = 32;
    localparam int PG_OFS_W = 12;
    localparam int VPN_W    = VA_W - PG_OFS_W;
    localparam int PPN_W    = 20;
    localparam int ASID_W   = 8;
    localparam int N_SETS   = 32;
    localparam int N_WAYS   = 4;
    localparam int IDX_W    = $clog2(N_SETS);
    localparam int TAG_W    = VPN_W - IDX_W;
    localparam int WIN_LSB  = 29;

    typedef struct packed {
        logic              valid;
        logic              shared;
        logic              cache;
        logic [ASID_W-1:0] asid;
        logic [TAG_W-1:0]  tag;
        logic [PPN_W-1:0]  ppn;
    } tlb_entry_t;

    typedef enum logic [2:0] {
        RG_USER,
        RG_ADDRERR,
        RG_KCACHED,
        RG_KUNCACHED,
        RG_KXLAT,
        RG_CTRL
    } region_e;

    function automatic logic [IDX_W-1:0] set_index(
        input logic              hashed,
        input logic [ASID_W-1:0] asid,
        input logic [IDX_W-1:0]  vpn_lo
    );
        return hashed ? (asid[IDX_W-1:0] ^ vpn_lo) : vpn_lo;
    endfunction
endpackage

// File: rtl/tlbx_region_dec.sv
module tlbx_region_dec
    import tlbx_pkg::*;
(
    input  logic [VA_W-1:0] va,
    output region_e         region
);
    localparam int TOP_W = VA_W - WIN_LSB;

    always_comb begin
        case (va[VA_W-1 -: TOP_W])
            3'b100:  region = RG_KCACHED;
            3'b101:  region = RG_KUNCACHED;
            3'b110:  region = RG_KXLAT;
            3'b111:  region = RG_CTRL;
            default: region = (va[VA_W-1 -: 6] == 6'b011111) ? RG_ADDRERR : RG_USER;
        endcase
    end
endmodule

// File: rtl/tlbx_store.sv
module tlbx_store
    import tlbx_pkg::*;
#(
    parameter int SETS = N_SETS,
    parameter int WAYS = N_WAYS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  tlb_entry_t        wr_entry,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [TAG_W-1:0]  rd_tag,
    input  logic [ASID_W-1:0] rd_asid,
    output logic              rd_hit,
    output logic [PPN_W-1:0]  rd_ppn,
    output logic              rd_cache
);
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

    tlb_entry_t       ent [SETS][WAYS];
    logic [WAY_W-1:0] rr  [SETS];
    logic [WAYS-1:0]  way_match;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    ent[s][w].valid <= 1'b0;
                end
                if (rst) rr[s] <= '0;
            end
        end else if (wr_en) begin
            ent[wr_idx][rr[wr_idx]] <= wr_entry;
            rr[wr_idx] <= (rr[wr_idx] == WAY_W'(WAYS - 1)) ? '0 : rr[wr_idx] + 1'b1;
        end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        tlb_entry_t e;
        assign e = ent[rd_idx][w];
        assign way_match[w] = e.valid && (e.tag == rd_tag) &&
                              (e.shared || (e.asid == rd_asid));
    end

    always_comb begin
        rd_hit   = 1'b0;
        rd_ppn   = '0;
        rd_cache = 1'b0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (way_match[w]) begin
                rd_hit   = 1'b1;
                rd_ppn   = ent[rd_idx][w].ppn;
                rd_cache = ent[rd_idx][w].cache;
            end
        end
    end
endmodule

// File: rtl/hashtlb_top.sv
module hashtlb_top
    import tlbx_pkg::*;
#(
    parameter int SETS = N_SETS,
    parameter int WAYS = N_WAYS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_va,
    input  logic [ASID_W-1:0] cur_asid,
    input  logic              hash_en,
    input  logic              wr_en,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [PPN_W-1:0]  wr_ppn,
    input  logic              wr_cache,
    input  logic              wr_shared,
    input  logic              flush_all,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic              rsp_addr_err,
    output logic [VA_W-1:0]   rsp_pa,
    output logic              rsp_cacheable
);
    region_e          region;
    tlb_entry_t       new_ent;
    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic             lk_hit, lk_cache;
    logic [PPN_W-1:0] lk_ppn;
    logic             n_hit, n_miss, n_err, n_cache;
    logic [VA_W-1:0]  n_pa;

    tlbx_region_dec u_dec (.va(req_va), .region(region));

    assign rd_idx = set_index(hash_en, cur_asid, req_va[PG_OFS_W +: IDX_W]);
    assign wr_idx = set_index(hash_en, wr_asid, wr_vpn[IDX_W-1:0]);

    always_comb begin
        new_ent        = '0;
        new_ent.valid  = 1'b1;
        new_ent.shared = wr_shared;
        new_ent.cache  = wr_cache;
        new_ent.asid   = wr_asid;
        new_ent.tag    = wr_vpn[VPN_W-1:IDX_W];
        new_ent.ppn    = wr_ppn;
    end

    tlbx_store #(.SETS(SETS), .WAYS(WAYS)) u_store (
        .clk(clk), .rst(rst), .flush(flush_all),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_entry(new_ent),
        .rd_idx(rd_idx), .rd_tag(req_va[VA_W-1:PG_OFS_W+IDX_W]), .rd_asid(cur_asid),
        .rd_hit(lk_hit), .rd_ppn(lk_ppn), .rd_cache(lk_cache)
    );

    always_comb begin
        n_hit = 1'b0; n_miss = 1'b0; n_err = 1'b0; n_cache = 1'b0; n_pa = '0;
        if (req_valid) begin
            case (region)
                RG_ADDRERR: n_err = 1'b1;
                RG_KCACHED: begin
                    n_hit = 1'b1; n_cache = 1'b1;
                    n_pa  = {{(VA_W-WIN_LSB){1'b0}}, req_va[WIN_LSB-1:0]};
                end
                RG_KUNCACHED: begin
                    n_hit = 1'b1;
                    n_pa  = {{(VA_W-WIN_LSB){1'b0}}, req_va[WIN_LSB-1:0]};
                end
                RG_CTRL: begin
                    n_hit = 1'b1;
                    n_pa  = req_va;
                end
                default: begin
                    if (lk_hit) begin
                        n_hit   = 1'b1;
                        n_cache = lk_cache;
                        n_pa    = {lk_ppn, req_va[PG_OFS_W-1:0]};
                    end else begin
                        n_miss = 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0; rsp_hit <= 1'b0; rsp_miss <= 1'b0;
            rsp_addr_err <= 1'b0; rsp_pa <= '0; rsp_cacheable <= 1'b0;
        end else begin
            rsp_valid <= req_valid; rsp_hit <= n_hit; rsp_miss <= n_miss;
            rsp_addr_err <= n_err; rsp_pa <= n_pa; rsp_cacheable <= n_cache;
        end
    end
endmodule

// File: rtl/tlbx_chk.sv
module tlbx_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [31:0] req_va,
    input logic        rsp_valid,
    input logic        rsp_hit,
    input logic        rsp_miss,
    input logic        rsp_addr_err,
    input logic [31:0] rsp_pa,
    input logic        rsp_cacheable
);
    // R9
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    // R9
    idle_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid && !rsp_hit && !rsp_miss && !rsp_addr_err);
    // R9
    one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_addr_err}) == 1);
    // R9
    miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_miss |-> (rsp_pa == 32'h0) && !rsp_cacheable);
    // R1
    offset_keep_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (!rsp_hit || (rsp_pa[11:0] == $past(req_va[11:0]))));
    // R8
    reserved_err_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_va[31:26] == 6'b011111) |=>
            rsp_addr_err && (rsp_pa == 32'h0) && !rsp_cacheable);
    // R5
    kcached_win_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_va[31:29] == 3'b100) |=>
            rsp_hit && rsp_cacheable && (rsp_pa == {3'b000, $past(req_va[28:0])}));
    // R6
    kuncached_win_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_va[31:29] == 3'b101) |=>
            rsp_hit && !rsp_cacheable && (rsp_pa == {3'b000, $past(req_va[28:0])}));
    // R7
    ctrl_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_va[31:29] == 3'b111) |=>
            rsp_hit && !rsp_cacheable && (rsp_pa == $past(req_va)));
endmodule

bind hashtlb_top tlbx_chk u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_va(req_va),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_addr_err(rsp_addr_err), .rsp_pa(rsp_pa), .rsp_cacheable(rsp_cacheable)
);

// File: tb/hashtlb_top_test.sv
module hashtlb_top_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_va = '0;
    logic [7:0]  cur_asid = '0;
    logic        hash_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [19:0] wr_vpn = '0;
    logic [7:0]  wr_asid = '0;
    logic [19:0] wr_ppn = '0;
    logic        wr_cache = 1'b0;
    logic        wr_shared = 1'b0;
    logic        flush_all = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_addr_err, rsp_cacheable;
    logic [31:0] rsp_pa;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        logic        hit;
        logic        miss;
        logic        err;
        logic        cache;
        logic [31:0] pa;
        string       rq;
    } exp_t;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    hashtlb_top uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_va(req_va),
        .cur_asid(cur_asid), .hash_en(hash_en), .wr_en(wr_en), .wr_vpn(wr_vpn),
        .wr_asid(wr_asid), .wr_ppn(wr_ppn), .wr_cache(wr_cache),
        .wr_shared(wr_shared), .flush_all(flush_all), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_addr_err(rsp_addr_err),
        .rsp_pa(rsp_pa), .rsp_cacheable(rsp_cacheable)
    );

    // monitor: results appear one cycle after the request edge
    always @(negedge clk) begin
        if (!rst && !done && rsp_valid) begin
            checks++;
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL R9 unexpected result: actual valid=1 expected no result");
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (rsp_hit !== e.hit || rsp_miss !== e.miss || rsp_addr_err !== e.err ||
                    rsp_cacheable !== e.cache || rsp_pa !== e.pa) begin
                    fails++;
                    $display("FAIL %s actual hit=%b miss=%b err=%b c=%b pa=%h expected hit=%b miss=%b err=%b c=%b pa=%h",
                             e.rq, rsp_hit, rsp_miss, rsp_addr_err, rsp_cacheable, rsp_pa,
                             e.hit, e.miss, e.err, e.cache, e.pa);
                end
            end
        end
    end

    task automatic set_req(input logic [31:0] va, input logic [7:0] asid, input logic hs,
                           input logic h, input logic m, input logic er, input logic c,
                           input logic [31:0] pa, input string rq);
        exp_t e;
        req_valid = 1'b1; req_va = va; cur_asid = asid; hash_en = hs;
        e.hit = h; e.miss = m; e.err = er; e.cache = c; e.pa = pa; e.rq = rq;
        sb.push_back(e);
    endtask

    task automatic set_wr(input logic [19:0] vpn, input logic [7:0] asid, input logic hs,
                          input logic [19:0] ppn, input logic c, input logic sh);
        wr_en = 1'b1; wr_vpn = vpn; wr_asid = asid; hash_en = hs;
        wr_ppn = ppn; wr_cache = c; wr_shared = sh;
    endtask

    task automatic step();
        @(negedge clk);
        req_valid = 1'b0; wr_en = 1'b0; flush_all = 1'b0;
    endtask

    task automatic look(input logic [31:0] va, input logic [7:0] asid, input logic hs,
                        input logic h, input logic m, input logic er, input logic c,
                        input logic [31:0] pa, input string rq);
        set_req(va, asid, hs, h, m, er, c, pa, rq);
        step();
    endtask

    task automatic load(input logic [19:0] vpn, input logic [7:0] asid, input logic hs,
                        input logic [19:0] ppn, input logic c, input logic sh);
        set_wr(vpn, asid, hs, ppn, c, sh);
        step();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0 || rsp_pa !== 32'h0) begin
            fails++;
            $display("FAIL R9 reset state actual valid=%b hit=%b pa=%h expected 0 0 0",
                     rsp_valid, rsp_hit, rsp_pa);
        end
        rst = 1'b0;
        @(negedge clk);

        // bypass and special regions
        look(32'h8123_4567, 8'h00, 1'b0, 1, 0, 0, 1, 32'h0123_4567, "R5 cached window");
        look(32'h9FFF_FFFF, 8'h00, 1'b0, 1, 0, 0, 1, 32'h1FFF_FFFF, "R5 cached window top");
        look(32'hA012_3456, 8'h00, 1'b0, 1, 0, 0, 0, 32'h0012_3456, "R6 uncached window");
        look(32'hE000_0010, 8'h00, 1'b0, 1, 0, 0, 0, 32'hE000_0010, "R7 control region");
        look(32'h7C00_1000, 8'h00, 1'b0, 0, 0, 1, 0, 32'h0,         "R8 reserved start");
        look(32'h7FFF_FFFC, 8'h00, 1'b0, 0, 0, 1, 0, 32'h0,         "R8 reserved end");
        look(32'h0000_5000, 8'h00, 1'b0, 0, 1, 0, 0, 32'h0,         "R9 miss on empty TLB");

        // hashed index, ASID compare
        load(20'h12345, 8'h03, 1'b1, 20'hABCDE, 1'b1, 1'b0);
        look(32'h1234_5678, 8'h03, 1'b1, 1, 0, 0, 1, 32'hABCD_E678, "R2 R13 hashed hit");
        look(32'h1234_5678, 8'h04, 1'b1, 0, 1, 0, 0, 32'h0,         "R3 asid mismatch");
        look(32'h1234_5678, 8'h03, 1'b0, 0, 1, 0, 0, 32'h0,         "R2 unhashed index differs");

        // shared entry, plain index
        load(20'h00010, 8'h07, 1'b0, 20'h55555, 1'b0, 1'b1);
        look(32'h0001_0ABC, 8'h09, 1'b0, 1, 0, 0, 0, 32'h5555_5ABC, "R4 shared ignores asid");

        // index bits not in tag: vpn 0x00003 asid 2 -> set 1; vpn 0x00001 asid 0 -> set 1
        load(20'h00003, 8'h02, 1'b1, 20'h11111, 1'b1, 1'b1);
        look(32'h0000_1ABC, 8'h00, 1'b1, 1, 0, 0, 1, 32'h1111_1ABC, "R3 index bits excluded from tag");

        // upper translated kernel region
        load(20'hC0002, 8'h03, 1'b1, 20'h0DEAD, 1'b1, 1'b0);
        look(32'hC000_2010, 8'h03, 1'b1, 1, 0, 0, 1, 32'h0DEA_D010, "R13 upper region via TLB");

        // round robin in set 0x1F, five loads
        for (int t = 1; t <= 5; t++) begin
            load(20'((t << 5) | 'h1F), 8'h00, 1'b0, 20'(32'h20000 + t), 1'b1, 1'b0);
        end
        look(32'h0003_F000, 8'h00, 1'b0, 0, 1, 0, 0, 32'h0,         "R10 fifth load replaced way 0");
        look(32'h0005_F000, 8'h00, 1'b0, 1, 0, 0, 1, 32'h2000_2000, "R10 second load kept");
        look(32'h000B_F000, 8'h00, 1'b0, 1, 0, 0, 1, 32'h2000_5000, "R10 fifth load present");

        // lookup and load in the same cycle
        set_wr(20'h00040, 8'h00, 1'b0, 20'h30000, 1'b1, 1'b0);
        set_req(32'h0004_0000, 8'h00, 1'b0, 0, 1, 0, 0, 32'h0, "R12 same-cycle load unseen");
        step();
        look(32'h0004_0000, 8'h00, 1'b0, 1, 0, 0, 1, 32'h3000_0000, "R12 load visible next");

        // lookup and flush in the same cycle
        flush_all = 1'b1;
        set_req(32'h0004_0000, 8'h00, 1'b0, 1, 0, 0, 1, 32'h3000_0000, "R12 same-cycle flush unseen");
        step();
        look(32'h0004_0000, 8'h00, 1'b0, 0, 1, 0, 0, 32'h0, "R11 flushed entry");
        look(32'h1234_5678, 8'h03, 1'b1, 0, 1, 0, 0, 32'h0, "R11 all sets flushed");

        // flush beats a load
        flush_all = 1'b1;
        set_wr(20'h00050, 8'h00, 1'b0, 20'h44444, 1'b1, 1'b0);
        step();
        look(32'h0005_0000, 8'h00, 1'b0, 0, 1, 0, 0, 32'h0, "R11 load dropped under flush");
        look(32'hBFFF_F123, 8'h00, 1'b0, 1, 0, 0, 0, 32'h1FFF_F123, "R6 R1 window end");

        repeat (3) @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R9 missing results: actual pending=%0d expected 0", sb.size());
        end
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule